// File: doc/BRIEF.md
# Timer Update Event Controller

This block is a 16-bit up-counting timer with a programmable clock divider and one compare channel. Its purpose is to decide when an update event happens and what follows from it. An update event copies the period, divider and compare values that software has written into the working (shadow) copies the counter uses. The event can come from a counter wrap or from a software request. Two control bits gate it: one blocks update events altogether, and the other lets only counter wraps raise the update flag.

Software reaches the block through a plain register port that has one write strobe, a byte address and a combinational read path. It has three status flags: update, compare match and compare overrun. Software clears each flag by writing zero to it. Each interrupt line is high when its flag is set and its enable bit is set.

Top module: `tmr_upd_ctl`

## Requirements
- R1: After reset, control (0x00), interrupt enable (0x0C), status (0x10) and count (0x24) read 0, and the period register (0x18) reads 0xFFFF. Both interrupt lines are low.
- R2: Control bit 0 (run) set to 1 lets the timer advance. Set to 0, the count holds its value.
- R3: The divider produces one count step every (divider shadow + 1) clocks while running. The divider register is at 0x1C. The count climbs from 0 to the period shadow value. The next step returns it to 0, and that step is a wrap.
- R4: Control bit 1 (block) at 0 means a wrap, or writing 1 to bit 0 of the event register (0x14), is an update event. An update event loads the shadows from the period, divider and compare (0x20) registers, so later counting follows the new values.
- R5: Control bit 1 at 1 means no update event happens. The shadows keep their values, and the update flag is not set. A write of 1 to event bit 0 still returns the count and the divider to 0.
- R6: Control bit 2 (wrap-only) at 0 means both wraps and software requests set the update flag (status bit 0). At 1, only wraps set it. A software request still resets the count and loads the shadows.
- R7: The compare flag (status bit 1) is set when a count step lands on the compare shadow value. If a step lands on it while the flag is already set, the overrun flag (status bit 9) is set as well.
- R8: Writing 0 to a status bit clears it, and writing 1 leaves it unchanged. When hardware sets a flag in the same cycle as software clears it, the flag ends up set.
- R9: The update interrupt equals status bit 0 AND enable bit 0. The compare interrupt equals status bit 1 AND enable bit 1. Flags are set whether or not their interrupt is enabled.
- R10: The event register always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq_upd | output | 1 | Update interrupt |
| irq_cmp | output | 1 | Compare interrupt |

## Verification
On every cycle, the assertions check five things:
- a stopped timer holds its count;
- a software request zeroes the count on the next clock;
- the shadows stay frozen while update events are blocked;
- a wrap always leaves the update flag set;
- the wrap-only mode never raises the flag without a wrap.

Other behaviour can only be shown by the directed scenarios:
- the exact step cadence under a given divider;
- the wrap point before and after a shadow load;
- the compare and overrun sequence;
- a clear landing on the very clock of a wrap;
- the link between flags, enables and interrupt lines.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam logic [7:0] ADR_CTRL = 8'h00;
    localparam logic [7:0] ADR_IEN  = 8'h0C;
    localparam logic [7:0] ADR_STS  = 8'h10;
    localparam logic [7:0] ADR_EVG  = 8'h14;
    localparam logic [7:0] ADR_PER  = 8'h18;
    localparam logic [7:0] ADR_DIV  = 8'h1C;
    localparam logic [7:0] ADR_CMP  = 8'h20;
    localparam logic [7:0] ADR_CNT  = 8'h24;

    localparam int STS_UPD = 0;
    localparam int STS_CMP = 1;
    localparam int STS_OVC = 9;

    // bit 2 wrap-only, bit 1 block, bit 0 run
    typedef struct packed {
        logic ovf_only;
        logic upd_off;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic ovc;
        logic cmp;
        logic upd;
    } flags_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         restart,
    input  logic [W-1:0] div_sh,
    output logic         tick
);
    logic [W-1:0] div_d, div_q;

    always_comb begin
        tick  = run && !restart && (div_q >= div_sh);
        div_d = div_q;
        if (restart)   div_d = '0;
        else if (tick) div_d = '0;
        else if (run)  div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // R5: a software request restarts the divider
    a_r5_div_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (div_q == '0));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         restart,
    input  logic [W-1:0] per_sh,
    input  logic [W-1:0] cmp_sh,
    output logic [W-1:0] cnt,
    output logic         wrap,
    output logic         hit
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        wrap  = tick && !restart && (cnt_q >= per_sh);
        cnt_d = cnt_q;
        if (restart)   cnt_d = '0;
        else if (tick) cnt_d = wrap ? '0 : cnt_q + 1'b1;
        hit = tick && !restart && (cnt_d == cmp_sh);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R2: without a step or a restart the count holds
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(cnt_q));
    // R5: software request zeroes the count
    a_r5_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags
    import tmr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   upd_off,
    input  logic   ovf_only,
    input  logic   wrap,
    input  logic   sw_upd,
    input  logic   hit,
    input  logic   sts_wr,
    input  flags_t sts_keep,
    output flags_t flags
);
    flags_t f_d, f_q;
    flags_t keep;
    logic   set_upd;

    always_comb begin
        keep    = sts_wr ? sts_keep : 3'b111;
        set_upd = !upd_off && (wrap || (sw_upd && !ovf_only));
        f_d.upd = (f_q.upd && keep.upd) || set_upd;
        f_d.cmp = (f_q.cmp && keep.cmp) || hit;
        f_d.ovc = (f_q.ovc && keep.ovc) || (hit && f_q.cmp);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign flags = f_q;

    // R8: a wrap with events allowed leaves the flag set, even against a clear
    a_r8_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !upd_off) |=> f_q.upd);
    // R6: in wrap-only mode a clear flag stays clear without a wrap
    a_r6_wrap_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!f_q.upd && ovf_only && !wrap) |=> !f_q.upd);
endmodule

// File: rtl/tmr_upd_ctl.sv
module tmr_upd_ctl
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_wr,
    input  logic [7:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    output logic         irq_upd,
    output logic         irq_cmp
);
    localparam int IEN_W = 2;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [IEN_W-1:0] ien;
        logic [W-1:0]     per_pl;
        logic [W-1:0]     div_pl;
        logic [W-1:0]     cmp_pl;
        logic [W-1:0]     per_sh;
        logic [W-1:0]     div_sh;
        logic [W-1:0]     cmp_sh;
    } regs_t;

    regs_t  r_d, r_q;
    logic   sw_upd, uev, tick, wrap, hit, sts_wr;
    logic [W-1:0] cnt;
    flags_t flags, sts_keep;

    assign sw_upd   = bus_wr && (bus_addr == ADR_EVG) && bus_wdata[0];
    assign sts_wr   = bus_wr && (bus_addr == ADR_STS);
    assign sts_keep = '{ovc: bus_wdata[STS_OVC], cmp: bus_wdata[STS_CMP], upd: bus_wdata[STS_UPD]};
    assign uev      = !r_q.ctrl.upd_off && (wrap || sw_upd);

    always_comb begin
        r_d = r_q;
        if (bus_wr) begin
            case (bus_addr)
                ADR_CTRL: r_d.ctrl   = ctrl_t'(bus_wdata[2:0]);
                ADR_IEN:  r_d.ien    = bus_wdata[IEN_W-1:0];
                ADR_PER:  r_d.per_pl = bus_wdata;
                ADR_DIV:  r_d.div_pl = bus_wdata;
                ADR_CMP:  r_d.cmp_pl = bus_wdata;
                default: ;
            endcase
        end
        if (uev) begin
            r_d.per_sh = r_q.per_pl;
            r_d.div_sh = r_q.div_pl;
            r_d.cmp_sh = r_q.cmp_pl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.per_pl <= '1;
            r_q.per_sh <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    tmr_prescale #(.W(W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(r_q.ctrl.run), .restart(sw_upd),
        .div_sh(r_q.div_sh), .tick(tick)
    );

    tmr_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .restart(sw_upd),
        .per_sh(r_q.per_sh), .cmp_sh(r_q.cmp_sh),
        .cnt(cnt), .wrap(wrap), .hit(hit)
    );

    tmr_flags u_flg (
        .clk(clk), .rst_n(rst_n), .upd_off(r_q.ctrl.upd_off),
        .ovf_only(r_q.ctrl.ovf_only), .wrap(wrap), .sw_upd(sw_upd), .hit(hit),
        .sts_wr(sts_wr), .sts_keep(sts_keep), .flags(flags)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_CTRL: bus_rdata[2:0] = r_q.ctrl;
            ADR_IEN:  bus_rdata[IEN_W-1:0] = r_q.ien;
            ADR_STS: begin
                bus_rdata[STS_UPD] = flags.upd;
                bus_rdata[STS_CMP] = flags.cmp;
                bus_rdata[STS_OVC] = flags.ovc;
            end
            ADR_PER:  bus_rdata = r_q.per_pl;
            ADR_DIV:  bus_rdata = r_q.div_pl;
            ADR_CMP:  bus_rdata = r_q.cmp_pl;
            ADR_CNT:  bus_rdata = cnt;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq_upd = flags.upd && r_q.ien[0];
    assign irq_cmp = flags.cmp && r_q.ien[1];

    // R5: shadows frozen while update events are blocked
    a_r5_shadow_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ctrl.upd_off |=> ($stable(r_q.per_sh) && $stable(r_q.div_sh) && $stable(r_q.cmp_sh)));
endmodule

// File: tb/tmr_upd_ctl_tb.sv
`timescale 1ns/1ps
module tmr_upd_ctl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        irq_upd, irq_cmp;
    int          n_chk = 0;
    int          n_err = 0;
    int          cyc = 0;

    always #10 clk = ~clk;

    tmr_upd_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_upd(irq_upd), .irq_cmp(irq_cmp)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_err = n_err + 1;
            n_chk = n_chk + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 20000", cyc);
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_err = n_err + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge
    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(8'h00, v); check("R1 ctrl", v, 16'h0);
        rd(8'h0C, v); check("R1 ien", v, 16'h0);
        rd(8'h10, v); check("R1 sts", v, 16'h0);
        rd(8'h24, v); check("R1 cnt", v, 16'h0);
        rd(8'h18, v); check("R1 period", v, 16'hFFFF);
        check("R1 irqs", {irq_upd, irq_cmp}, 2'b00);
    endtask

    task automatic t_div_two();
        logic [15:0] v;
        wr(8'h18, 16'd4); wr(8'h1C, 16'd1); wr(8'h20, 16'd2);
        wr(8'h14, 16'h0001);
        rd(8'h10, v); check("R6 sw request sets update flag", v, 16'h0001);
        rd(8'h14, v); check("R10 event reg reads 0", v, 16'h0);
        check("R9 flag set with irq disabled", irq_upd, 1'b0);
        wr(8'h10, 16'h0000);
        wr(8'h00, 16'h0001);
        bus_addr = 8'h24;
        for (int k = 1; k <= 10; k++) begin
            step();
            check("R3 div-by-2 count", bus_rdata, 16'((k / 2) % 5));
        end
        rd(8'h10, v); check("R7 match and R3 wrap flags", v, 16'h0003);
        wr(8'h00, 16'h0000);
        wr(8'h0C, 16'h0003);
        check("R9 irq lines", {irq_upd, irq_cmp}, 2'b11);
    endtask

    task automatic t_clear();
        logic [15:0] v;
        wr(8'h10, 16'hFFFE);
        rd(8'h10, v); check("R8 write 0 clears, 1 keeps", v, 16'h0002);
        check("R9 irq after clear", {irq_upd, irq_cmp}, 2'b01);
        wr(8'h10, 16'h0000);
        rd(8'h10, v); check("R8 clear all", v, 16'h0);
    endtask

    task automatic t_wrap_only();
        logic [15:0] v;
        wr(8'h18, 16'd2); wr(8'h1C, 16'd0);
        wr(8'h00, 16'h0004);
        wr(8'h14, 16'h0001);
        rd(8'h10, v); check("R6 wrap-only ignores sw request flag", v, 16'h0);
        wr(8'h00, 16'h0005);
        bus_addr = 8'h24;
        for (int k = 1; k <= 3; k++) begin
            step();
            check("R4 new period loaded by sw request", bus_rdata, 16'(k % 3));
        end
        rd(8'h10, v); check("R6 wrap sets flag in wrap-only", v, 16'h0003);
        bus_addr = 8'h24;
        step(); step();
        rd(8'h10, v); check("R7 overrun on second match", v, 16'h0203);
        wr(8'h00, 16'h0000);
        wr(8'h10, 16'h0000);
    endtask

    task automatic t_blocked();
        logic [15:0] v;
        wr(8'h18, 16'd6);
        wr(8'h00, 16'h0003);
        bus_addr = 8'h24;
        for (int k = 1; k <= 6; k++) begin
            step();
            check("R5 old period kept while blocked", bus_rdata, 16'(k % 3));
            if (k == 3) begin
                rd(8'h10, v); check("R5 no update flag while blocked", v[0], 1'b0);
                bus_addr = 8'h24;
            end
        end
        wr(8'h00, 16'h0002);
        rd(8'h24, v); check("R2 count holds when stopped", v, 16'd1);
        step();
        rd(8'h24, v); check("R2 still holding", v, 16'd1);
        wr(8'h14, 16'h0001);
        rd(8'h24, v); check("R5 sw request zeroes count when blocked", v, 16'd0);
        rd(8'h10, v); check("R5 sw request no flag when blocked", v[0], 1'b0);
        wr(8'h10, 16'h0000);
        wr(8'h00, 16'h0001);
        bus_addr = 8'h24;
        for (int k = 1; k <= 9; k++) begin
            step();
            check("R4 wrap loads new period", bus_rdata, (k <= 3) ? 16'(k % 3) : 16'(k - 3));
        end
        wr(8'h10, 16'h0000);
        rd(8'h10, v); check("R8 hardware set beats clear", v, 16'h0001);
        check("R9 update irq", irq_upd, 1'b1);
        wr(8'h00, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_div_two();
        t_clear();
        t_wrap_only();
        t_blocked();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule